// File: doc/BRIEF.md
# Interrupt Priority Register Bank

This block stores one 8-bit priority byte for each peripheral interrupt and the 3-bit priority-grouping selector that a downstream arbiter uses to split each byte into a preemption part and a sub-priority part. Software reaches the bank over a simple word-addressed register bus with 32-bit data and per-byte strobes. Each 32-bit priority word carries four interrupts' bytes. The arbiter sees every priority byte and the grouping selector at once, on flat registered outputs.

A parameter sets how many priority bits are actually stored, from 2 to 8. The stored bits sit at the top of each byte. The low bits are dropped on write and always appear as zero, on the bus and on the flat output. A second parameter sets the interrupt count, up to 64. Priority words sit at word addresses 0 upward. The grouping selector lives in a separate control word at a parameterised word address.

Top module: `irq_prio_bank`

## Requirements
- R1: After a cycle with `rst` high, every priority byte, the grouping selector and `bus_rdata` are zero.
- R2: Interrupt m is held in priority word m/4, in bits [8*(m%4)+7 : 8*(m%4)] of that word, and drives `prio_flat[8*m+7 : 8*m]`.
- R3: With P implemented bits, only bits [7 : 8-P] of a written byte are kept. Bits [7-P : 0] read as zero on the bus and on `prio_flat`. With P=2, only bits [7:6] survive, which gives 4 levels.
- R4: A write updates only the byte lanes whose `bus_be` bit is set. Lane k is bits [8k+7 : 8k]. The other lanes of that word keep their value.
- R5: The grouping selector is bits [10:8] of the control word at word address `CTRL_ADDR`. It is written only when `bus_be[1]` is set, and the control word reads as {21'b0, selector, 8'b0}.
- R6: A write to any address other than the implemented priority words and `CTRL_ADDR` changes nothing, and a read of such an address returns zero.
- R7: Read data is registered. It appears in the cycle after a read request (`bus_en`=1, `bus_wr`=0) and holds its value in all other cycles, including write cycles.
- R8: A write becomes visible on `prio_flat` and `group_sel` in the cycle after the write request. Without a write, these outputs hold their value.
- R9: When the interrupt count is not a multiple of 4, the unused lanes of the last priority word ignore writes and read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte-lane write strobes |
| bus_rdata | output | 32 | Registered read data |
| prio_flat | output | NUM_IRQ*8 | All priority bytes, interrupt m at byte m |
| group_sel | output | 3 | Priority-grouping selector |

## Verification
A corrupted stored byte appears on `prio_flat` at the next falling edge. It also appears in `bus_rdata` one cycle after a read of its word, so the scoreboard sees a wrong lane, a wrong word mapping or stray low bits within two cycles of the access. A decode fault that lets an out-of-range or strobe-less write through shows up as a changed flat output right after that write. This holds even with no read, because the bench compares the whole flat vector against its model after every write.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  typedef enum logic [1:0] {ACC_NONE, ACC_PRIO, ACC_CTRL} acc_kind_e;

  localparam int GRP_LSB = 8;
  localparam int GRP_W   = 3;

  function automatic logic [7:0] impl_mask(input int bits);
    return 8'hFF << (8 - bits);
  endfunction
endpackage

// File: rtl/irq_prio_decode.sv
module irq_prio_decode
  import irq_prio_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NUM_WORDS = 8,
  parameter int IDX_W = 3,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 6'h20
) (
  input  logic [ADDR_W-1:0] addr,
  output acc_kind_e         kind,
  output logic [IDX_W-1:0]  idx
);
  localparam logic [ADDR_W-1:0] WORD_END = ADDR_W'(NUM_WORDS);

  always_comb begin
    idx = addr[IDX_W-1:0];
    if (addr == CTRL_ADDR)    kind = ACC_CTRL;
    else if (addr < WORD_END) kind = ACC_PRIO;
    else                      kind = ACC_NONE;
  end
endmodule

// File: rtl/irq_prio_field.sv
module irq_prio_field #(
  parameter int PRIO_BITS = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [7:0] wbyte,
  output logic [7:0] q
);
  logic [PRIO_BITS-1:0] held;

  always_ff @(posedge clk) begin
    if (rst)     held <= '0;
    else if (we) held <= wbyte[7 -: PRIO_BITS];
  end

  generate
    if (PRIO_BITS == 8) begin : g_full
      assign q = held;
    end else begin : g_part
      assign q = {held, {(8-PRIO_BITS){1'b0}}};
    end
  endgenerate
endmodule

// File: rtl/irq_prio_group.sv
module irq_prio_group
  import irq_prio_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [GRP_W-1:0] wval,
  output logic [GRP_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= wval;
  end
endmodule

// File: rtl/irq_prio_bank.sv
module irq_prio_bank
  import irq_prio_pkg::*;
#(
  parameter int NUM_IRQ = 30,
  parameter int PRIO_BITS = 4,
  parameter int ADDR_W = 6,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 6'h20
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_en,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  input  logic [3:0]           bus_be,
  output logic [31:0]          bus_rdata,
  output logic [NUM_IRQ*8-1:0] prio_flat,
  output logic [2:0]           group_sel
);
  localparam int NUM_WORDS = (NUM_IRQ + 3) / 4;
  localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

  acc_kind_e                    kind;
  logic [IDX_W-1:0]             idx;
  logic                         wr_req;
  logic                         rd_req;
  logic [NUM_WORDS-1:0][31:0]   words;
  logic [31:0]                  rd_next;

  assign wr_req = bus_en && bus_wr;
  assign rd_req = bus_en && !bus_wr;

  irq_prio_decode #(
    .ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W), .CTRL_ADDR(CTRL_ADDR)
  ) u_dec (
    .addr(bus_addr), .kind(kind), .idx(idx)
  );

  genvar gi, gl;
  generate
    for (gi = 0; gi < NUM_IRQ; gi++) begin : g_irq
      logic lane_we;
      assign lane_we = wr_req && (kind == ACC_PRIO) &&
                       (idx == IDX_W'(gi / 4)) && bus_be[gi % 4];
      irq_prio_field #(.PRIO_BITS(PRIO_BITS)) u_fld (
        .clk(clk), .rst(rst), .we(lane_we),
        .wbyte(bus_wdata[8*(gi%4) +: 8]),
        .q(prio_flat[8*gi +: 8])
      );
    end

    for (gi = 0; gi < NUM_WORDS; gi++) begin : g_word
      for (gl = 0; gl < 4; gl++) begin : g_lane
        if (gi*4 + gl < NUM_IRQ) begin : g_used
          assign words[gi][8*gl +: 8] = prio_flat[8*(gi*4+gl) +: 8];
        end else begin : g_empty
          assign words[gi][8*gl +: 8] = 8'h00;
        end
      end
    end
  endgenerate

  irq_prio_group u_grp (
    .clk(clk), .rst(rst),
    .we(wr_req && (kind == ACC_CTRL) && bus_be[1]),
    .wval(bus_wdata[GRP_LSB +: GRP_W]),
    .q(group_sel)
  );

  always_comb begin
    case (kind)
      ACC_PRIO: rd_next = words[idx];
      ACC_CTRL: rd_next = {21'b0, group_sel, 8'b0};
      default:  rd_next = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= 32'h0;
    else if (rd_req) bus_rdata <= rd_next;
  end
endmodule

// File: rtl/irq_prio_bank_chk.sv
module irq_prio_bank_chk #(
  parameter int NUM_IRQ = 30,
  parameter int PRIO_BITS = 4,
  parameter int ADDR_W = 6,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 6'h20
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 bus_en,
  input logic                 bus_wr,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [3:0]           bus_be,
  input logic [31:0]          bus_rdata,
  input logic [NUM_IRQ*8-1:0] prio_flat,
  input logic [2:0]           group_sel
);
  localparam int NUM_WORDS = (NUM_IRQ + 3) / 4;
  localparam logic [ADDR_W-1:0] WORD_END = ADDR_W'(NUM_WORDS);
  localparam logic [7:0] LOW_MASK = ~irq_prio_pkg::impl_mask(PRIO_BITS);

  logic low_any;
  always_comb begin
    low_any = 1'b0;
    for (int i = 0; i < NUM_IRQ; i++)
      low_any = low_any | (|(prio_flat[8*i +: 8] & LOW_MASK));
  end

  a_r1_reset_zero: assert property (@(posedge clk)
    rst |=> (prio_flat == '0 && group_sel == 3'd0 && bus_rdata == 32'h0));

  a_r3_low_bits_zero: assert property (@(posedge clk) disable iff (rst)
    !low_any);

  a_r5_group_needs_lane1: assert property (@(posedge clk) disable iff (rst)
    (bus_en && bus_wr && !bus_be[1]) |=> $stable(group_sel));

  a_r6_unmapped_write: assert property (@(posedge clk) disable iff (rst)
    (bus_en && bus_wr && bus_addr >= WORD_END && bus_addr != CTRL_ADDR)
      |=> ($stable(prio_flat) && $stable(group_sel)));

  a_r7_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !(bus_en && !bus_wr) |=> $stable(bus_rdata));

  a_r8_hold_without_write: assert property (@(posedge clk) disable iff (rst)
    !(bus_en && bus_wr) |=> ($stable(prio_flat) && $stable(group_sel)));
endmodule

bind irq_prio_bank irq_prio_bank_chk #(
  .NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .bus_en(bus_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_be(bus_be), .bus_rdata(bus_rdata), .prio_flat(prio_flat), .group_sel(group_sel)
);

// File: tb/sim_irq_prio_bank.sv
module sim_irq_prio_bank;
  localparam int NIRQ = 30;
  localparam int PB = 4;
  localparam int AW = 6;
  localparam int NW = (NIRQ + 3) / 4;
  localparam logic [AW-1:0] CADDR = 6'h20;
  localparam logic [7:0] MSK = 8'hFF << (8 - PB);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_en = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0] bus_be = '0;
  logic [31:0] rdata0, rdata1;
  logic [NIRQ*8-1:0] flat0;
  logic [63:0] flat1;
  logic [2:0] grp0, grp1;

  always #5 clk = ~clk;

  irq_prio_bank #(.NUM_IRQ(NIRQ), .PRIO_BITS(PB), .ADDR_W(AW), .CTRL_ADDR(CADDR)) u0 (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(rdata0),
    .prio_flat(flat0), .group_sel(grp0));

  irq_prio_bank #(.NUM_IRQ(8), .PRIO_BITS(2), .ADDR_W(AW), .CTRL_ADDR(CADDR)) u1 (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(rdata1),
    .prio_flat(flat1), .group_sel(grp1));

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] model [NIRQ];
  logic [2:0] model_grp = '0;
  logic [31:0] expq [$];
  logic [31:0] last_rd = '0;
  logic rd_seen = 1'b0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input logic [AW-1:0] a);
    logic [31:0] w = '0;
    if (a == CADDR) w = {21'b0, model_grp, 8'b0};
    else if (int'(a) < NW)
      for (int l = 0; l < 4; l++)
        if (int'(a)*4 + l < NIRQ) w[8*l +: 8] = model[int'(a)*4 + l];
    return w;
  endfunction

  task automatic check_flat(input string req);
    logic [NIRQ*8-1:0] e;
    for (int i = 0; i < NIRQ; i++) e[8*i +: 8] = model[i];
    checks++;
    if (flat0 !== e) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, flat0, e);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_en = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_en = 0; bus_wr = 0; bus_be = '0;
    if (a == CADDR) begin
      if (be[1]) model_grp = d[10:8];
    end else if (int'(a) < NW) begin
      for (int l = 0; l < 4; l++)
        if (be[l] && int'(a)*4 + l < NIRQ) model[int'(a)*4 + l] = d[8*l +: 8] & MSK;
    end
  endtask

  task automatic bus_read(input logic [AW-1:0] a);
    @(negedge clk);
    bus_en = 1; bus_wr = 0; bus_addr = a;
    expq.push_back(exp_word(a));
    @(negedge clk);
    bus_en = 0;
  endtask

  // Monitor: a read request seen at a rising edge has its data at the next falling edge.
  always @(posedge clk) rd_seen <= bus_en && !bus_wr && !rst;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (expq.size() == 0) begin
        checks++; errors++;
        $display("FAIL R7: actual=unexpected read data %h expected=none", rdata0);
      end else begin
        last_rd = expq.pop_front();
        check("R2/R7 read word", {32'h0, rdata0}, {32'h0, last_rd});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NIRQ; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    check("R1 flat", {63'h0, |flat0}, 64'h0);
    check("R1 group", {61'h0, grp0}, 64'h0);
    check("R1 rdata", {32'h0, rdata0}, 64'h0);
    for (int w = 0; w < NW; w++) bus_read(AW'(w));
    bus_read(CADDR);

    // R3/R2: full word, low bits dropped
    bus_write(6'd0, 32'hFFFF_FFFF, 4'hF);
    check_flat("R8 flat after write");
    check("R3 word0 flat", {32'h0, flat0[31:0]}, 64'hF0F0_F0F0);
    check("R3 two-bit variant", flat1[31:0], 32'hC0C0_C0C0);
    bus_read(6'd0);

    // R2: lane mapping
    bus_write(6'd1, 32'h1234_5678, 4'hF);
    check("R2 irq4 lane0", {56'h0, flat0[39:32]}, 64'h70);
    check("R2 irq7 lane3", {56'h0, flat0[63:56]}, 64'h10);
    bus_read(6'd1);

    // R4: byte strobes
    bus_write(6'd1, 32'hAAAA_AAAA, 4'b0101);
    check_flat("R4 strobe lanes");
    check("R4 word1 flat", {32'h0, flat0[63:32]}, 64'h10A0_50A0);
    bus_read(6'd1);
    bus_write(6'd0, 32'h0000_0000, 4'h0);
    check_flat("R4 no strobes");

    // R9: partial last word
    bus_write(AW'(NW-1), 32'hFFFF_FFFF, 4'hF);
    check_flat("R9 last word");
    bus_read(AW'(NW-1));

    // R6: beyond range and unmapped
    bus_write(AW'(NW), 32'hFFFF_FFFF, 4'hF);
    check_flat("R6 beyond range");
    bus_write(6'h30, 32'hFFFF_FFFF, 4'hF);
    check_flat("R6 unmapped");
    check("R6 group untouched", {61'h0, grp0}, 64'h0);
    bus_read(AW'(NW));
    bus_read(6'h30);

    // R5: grouping field
    bus_write(CADDR, 32'h0000_0500, 4'b0010);
    check("R5 group set", {61'h0, grp0}, 64'd5);
    bus_write(CADDR, 32'h0000_0700, 4'b1101);
    check("R5 group needs lane1", {61'h0, grp0}, 64'd5);
    bus_read(CADDR);
    bus_write(CADDR, 32'hFFFF_FFFF, 4'hF);
    check("R5 group max", {61'h0, grp0}, 64'd7);
    bus_read(CADDR);

    // R7: read data holds across writes and idle
    bus_write(6'd2, 32'h5555_5555, 4'hF);
    check("R7 hold after write", {32'h0, rdata0}, {32'h0, last_rd});
    repeat (2) @(negedge clk);
    check("R7 hold idle", {32'h0, rdata0}, 64'h700);
    bus_read(6'd2);

    for (int w = 0; w < NW; w++) bus_read(AW'(w));
    @(negedge clk);
    check("R7 queue drained", 64'(expq.size()), 64'h0);

    // R1: reset again clears everything
    rst = 1;
    @(negedge clk);
    rst = 0;
    for (int i = 0; i < NIRQ; i++) model[i] = 8'h00;
    model_grp = '0;
    check_flat("R1 flat after reset");
    check("R1 group after reset", {61'h0, grp0}, 64'h0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule